// File: doc/BRIEF.md
# Microcoded Unit Dispatch Sequencer

This block walks a small program memory of macro-operations and hands each one to a datapath unit. Every macro-op names exactly one target unit and carries a mode nibble, two scratchpad base addresses and an element count. When the sequencer meets an op for a real unit, it raises that unit's start line for a single cycle. It drives the operand fields on shared outputs, and then waits with its program counter frozen until the same unit reports done. Because of this handshake, units of any latency can be chained under a schedule held in memory, in place of a hardwired state machine.

The program image is a parameter, fixed when the block is elaborated. It is produced offline and encodes the complete schedule for one token. A run starts on a pulse of `run_i` while the block is idle. The block then fetches one op per cycle whenever it is not waiting. A terminating op pulses `token_done_o` and returns the counter to address zero, ready for the next token. A halt request stops dispatch at the next op boundary, and another `run_i` pulse resumes from the op that follows. A done pulse that no started unit could have produced is ignored and recorded in a sticky error flag.

Top module: `useq_dispatch`

## Requirements
- R1: After reset `pc_o` is 0, no `unit_start_o` bit is set, and `busy_o`, `halted_o`, `token_done_o` and `proto_err_o` are all low.
- R2: A `run_i` pulse while idle starts the program at address 0. A `run_i` pulse while the block is busy and not halted has no effect on the order or number of dispatches.
- R3: Each op whose select field (bits 35:32) is below NUM_UNITS produces exactly one start pulse. The pulse is one cycle wide, on the `unit_start_o` bit whose index equals the select value, and no other bit is set.
- R4: During the start cycle and on until done is accepted, `op_mode_o`, `op_base_a_o`, `op_base_b_o` and `op_count_o` hold the op's bits 31:28, 27:18, 17:8 and 7:0, unchanged.
- R5: After a start, the counter holds and no further start is issued until the started unit asserts its done bit. The next start then appears two cycles after the cycle in which done was high, plus one cycle for each skipped op.
- R6: An op whose select value is NUM_UNITS or more but below 15 starts no unit and costs one cycle.
- R7: Select value 15 ends the token. `token_done_o` pulses for one cycle, and in that cycle `busy_o` is low, `pc_o` is 0 and no start is set. The next `run_i` replays the program from op 0.
- R8: A one-cycle `halt_i` while running stops dispatch once the unit in flight has completed. `halted_o` and `busy_o` then stay high with no start pulses, and a `run_i` pulse resumes with the next op in order.
- R9: A done bit from a unit other than the one awaited, or any done bit while no unit is awaited, neither advances nor disturbs the program. It sets `proto_err_o`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Begin a token when idle, resume when halted |
| halt_i | input | 1 | Request a stop at the next op boundary |
| unit_done_i | input | NUM_UNITS | Per-unit completion pulses |
| unit_start_o | output | NUM_UNITS | Per-unit one-cycle start pulses |
| op_mode_o | output | 4 | Mode field of the dispatched op |
| op_base_a_o | output | 10 | First scratchpad base address |
| op_base_b_o | output | 10 | Second scratchpad base address |
| op_count_o | output | 8 | Element count |
| pc_o | output | PC_W | Current program address |
| busy_o | output | 1 | High from a run start until the token ends |
| halted_o | output | 1 | High while frozen by a halt |
| token_done_o | output | 1 | One-cycle pulse at the end-of-token op |
| proto_err_o | output | 1 | Sticky flag for unexpected done pulses |

## Verification
Some properties are checked on every cycle inside the design. A start vector has at most one bit set and never lasts two cycles. The counter and operand outputs stay still while a unit is awaited. No start appears while halted or at the end pulse. The error flag, once set, never clears. Only the bench's scenarios can show the ordering claims. These are that the dispatched units and fields follow the program, that skipped selects cost exactly one cycle, that the next start lands exactly two cycles after done, that a halted token resumes at the right op, and that stray done pulses leave the schedule untouched while varying unit latencies.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;

    localparam int SEL_W  = 4;
    localparam int MODE_W = 4;
    localparam int BASE_W = 10;
    localparam int CNT_W  = 8;
    localparam int WORD_W = SEL_W + MODE_W + 2 * BASE_W + CNT_W;

    localparam logic [SEL_W-1:0] SEL_END = '1;

    // Field order inside the word is significant: sel occupies the top bits.
    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [MODE_W-1:0] mode;
        logic [BASE_W-1:0] base_a;
        logic [BASE_W-1:0] base_b;
        logic [CNT_W-1:0]  count;
    } uop_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_HALT
    } seq_state_e;

endpackage

// File: rtl/useq_rom.sv
`timescale 1ns/1ps
module useq_rom #(
    parameter int DEPTH = 32,
    parameter int PC_W  = 5,
    parameter logic [DEPTH*useq_pkg::WORD_W-1:0] IMAGE = '1
) (
    input  logic [PC_W-1:0] addr_i,
    output useq_pkg::uop_t  op_o
);
    import useq_pkg::*;

    logic [WORD_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign words[g] = IMAGE[g*WORD_W +: WORD_W];
    end

    assign op_o = uop_t'(words[addr_i]);

endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl #(
    parameter int NUM_UNITS = 8,
    parameter int PC_W      = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_i,
    input  logic                     halt_i,
    input  logic [useq_pkg::SEL_W-1:0] sel_i,
    input  logic [NUM_UNITS-1:0]     done_i,
    output logic [PC_W-1:0]          pc_o,
    output logic                     fire_o,
    output logic [NUM_UNITS-1:0]     fire_oh_o,
    output logic [NUM_UNITS-1:0]     active_oh_o,
    output logic                     in_wait_o,
    output logic                     accept_o,
    output logic                     busy_o,
    output logic                     halted_o,
    output logic                     token_done_o
);
    import useq_pkg::*;

    typedef struct packed {
        seq_state_e             state;
        logic [PC_W-1:0]        pc;
        logic [NUM_UNITS-1:0]   active;
        logic                   halt_pend;
        logic                   token_done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [NUM_UNITS-1:0] sel_oh;
    logic                 sel_real;
    logic                 sel_end;
    logic                 accept;
    logic                 halt_now;
    logic                 fire;

    always_comb begin
        for (int i = 0; i < NUM_UNITS; i++) begin
            sel_oh[i] = (sel_i == SEL_W'(i));
        end
    end

    assign sel_real = (int'(sel_i) < NUM_UNITS);
    assign sel_end  = (sel_i == SEL_END);
    assign accept   = (c_q.state == ST_WAIT) && |(done_i & c_q.active);
    assign halt_now = halt_i | c_q.halt_pend;

    always_comb begin
        c_d            = c_q;
        c_d.token_done = 1'b0;
        fire           = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (run_i) begin
                    c_d.state     = ST_FETCH;
                    c_d.halt_pend = 1'b0;
                end
            end
            ST_FETCH: begin
                if (halt_now) begin
                    c_d.state     = ST_HALT;
                    c_d.halt_pend = 1'b0;
                end else if (sel_end) begin
                    c_d.token_done = 1'b1;
                    c_d.pc         = '0;
                    c_d.state      = ST_IDLE;
                end else if (sel_real) begin
                    fire       = 1'b1;
                    c_d.active = sel_oh;
                    c_d.state  = ST_WAIT;
                end else begin
                    c_d.pc = c_q.pc + 1'b1;
                end
            end
            ST_WAIT: begin
                if (halt_i) begin
                    c_d.halt_pend = 1'b1;
                end
                if (accept) begin
                    c_d.pc        = c_q.pc + 1'b1;
                    c_d.state     = halt_now ? ST_HALT : ST_FETCH;
                    c_d.halt_pend = 1'b0;
                end
            end
            ST_HALT: begin
                if (run_i && !halt_i) begin
                    c_d.state = ST_FETCH;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.state      <= ST_IDLE;
            c_q.pc         <= '0;
            c_q.active     <= '0;
            c_q.halt_pend  <= 1'b0;
            c_q.token_done <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pc_o         = c_q.pc;
    assign fire_o       = fire;
    assign fire_oh_o    = sel_oh;
    assign active_oh_o  = c_q.active;
    assign in_wait_o    = (c_q.state == ST_WAIT);
    assign accept_o     = accept;
    assign busy_o       = (c_q.state != ST_IDLE);
    assign halted_o     = (c_q.state == ST_HALT);
    assign token_done_o = c_q.token_done;

    // R5: the counter is frozen while an issued unit has not answered
    assert_pc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_WAIT && !accept) |=> (c_q.pc == $past(c_q.pc)));

endmodule

// File: rtl/useq_issue.sv
`timescale 1ns/1ps
module useq_issue #(
    parameter int NUM_UNITS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fire_i,
    input  logic [NUM_UNITS-1:0]        fire_oh_i,
    input  logic [useq_pkg::MODE_W-1:0] mode_i,
    input  logic [useq_pkg::BASE_W-1:0] base_a_i,
    input  logic [useq_pkg::BASE_W-1:0] base_b_i,
    input  logic [useq_pkg::CNT_W-1:0]  count_i,
    output logic [NUM_UNITS-1:0]        start_o,
    output logic [useq_pkg::MODE_W-1:0] mode_o,
    output logic [useq_pkg::BASE_W-1:0] base_a_o,
    output logic [useq_pkg::BASE_W-1:0] base_b_o,
    output logic [useq_pkg::CNT_W-1:0]  count_o
);
    import useq_pkg::*;

    typedef struct packed {
        logic [NUM_UNITS-1:0] start;
        logic [MODE_W-1:0]    mode;
        logic [BASE_W-1:0]    base_a;
        logic [BASE_W-1:0]    base_b;
        logic [CNT_W-1:0]     count;
    } issue_t;

    issue_t i_d, i_q;

    always_comb begin
        i_d       = i_q;
        i_d.start = '0;
        if (fire_i) begin
            i_d.start  = fire_oh_i;
            i_d.mode   = mode_i;
            i_d.base_a = base_a_i;
            i_d.base_b = base_b_i;
            i_d.count  = count_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_q <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    assign start_o  = i_q.start;
    assign mode_o   = i_q.mode;
    assign base_a_o = i_q.base_a;
    assign base_b_o = i_q.base_b;
    assign count_o  = i_q.count;

    // R3: never more than one unit started at once
    assert_start_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(i_q.start));

    // R3: a start never lasts past one cycle
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|i_q.start) |=> (i_q.start == '0));

endmodule

// File: rtl/useq_guard.sv
`timescale 1ns/1ps
module useq_guard #(
    parameter int NUM_UNITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] done_i,
    input  logic [NUM_UNITS-1:0] active_oh_i,
    input  logic                 in_wait_i,
    output logic                 err_o
);
    typedef struct packed {
        logic err;
    } guard_t;

    guard_t g_d, g_q;
    logic [NUM_UNITS-1:0] expected;
    logic                 stray;

    assign expected = in_wait_i ? active_oh_i : '0;
    assign stray    = |(done_i & ~expected);

    always_comb begin
        g_d     = g_q;
        g_d.err = g_q.err | stray;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign err_o = g_q.err;

    // R9: the protocol flag only clears through reset
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.err |=> g_q.err);

endmodule

// File: rtl/useq_dispatch.sv
`timescale 1ns/1ps
module useq_dispatch #(
    parameter int NUM_UNITS = 8,
    parameter int DEPTH     = 32,
    parameter int PC_W      = $clog2(DEPTH),
    parameter logic [DEPTH*useq_pkg::WORD_W-1:0] ROM_IMAGE = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_i,
    input  logic                        halt_i,
    input  logic [NUM_UNITS-1:0]        unit_done_i,
    output logic [NUM_UNITS-1:0]        unit_start_o,
    output logic [useq_pkg::MODE_W-1:0] op_mode_o,
    output logic [useq_pkg::BASE_W-1:0] op_base_a_o,
    output logic [useq_pkg::BASE_W-1:0] op_base_b_o,
    output logic [useq_pkg::CNT_W-1:0]  op_count_o,
    output logic [PC_W-1:0]             pc_o,
    output logic                        busy_o,
    output logic                        halted_o,
    output logic                        token_done_o,
    output logic                        proto_err_o
);
    import useq_pkg::*;

    uop_t                 cur_op;
    logic                 fire;
    logic [NUM_UNITS-1:0] fire_oh;
    logic [NUM_UNITS-1:0] active_oh;
    logic                 in_wait;
    logic                 accept;

    useq_rom #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W),
        .IMAGE (ROM_IMAGE)
    ) u_rom (
        .addr_i (pc_o),
        .op_o   (cur_op)
    );

    useq_ctrl #(
        .NUM_UNITS (NUM_UNITS),
        .PC_W      (PC_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_i),
        .halt_i       (halt_i),
        .sel_i        (cur_op.sel),
        .done_i       (unit_done_i),
        .pc_o         (pc_o),
        .fire_o       (fire),
        .fire_oh_o    (fire_oh),
        .active_oh_o  (active_oh),
        .in_wait_o    (in_wait),
        .accept_o     (accept),
        .busy_o       (busy_o),
        .halted_o     (halted_o),
        .token_done_o (token_done_o)
    );

    useq_issue #(
        .NUM_UNITS (NUM_UNITS)
    ) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire),
        .fire_oh_i (fire_oh),
        .mode_i    (cur_op.mode),
        .base_a_i  (cur_op.base_a),
        .base_b_i  (cur_op.base_b),
        .count_i   (cur_op.count),
        .start_o   (unit_start_o),
        .mode_o    (op_mode_o),
        .base_a_o  (op_base_a_o),
        .base_b_o  (op_base_b_o),
        .count_o   (op_count_o)
    );

    useq_guard #(
        .NUM_UNITS (NUM_UNITS)
    ) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (unit_done_i),
        .active_oh_i (active_oh),
        .in_wait_i   (in_wait),
        .err_o       (proto_err_o)
    );

    // R4: operands do not move while the issued unit is still working
    assert_operands_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !accept) |=>
            $stable({op_mode_o, op_base_a_o, op_base_b_o, op_count_o}));

    // R7: the end pulse coincides with an idle, rewound sequencer
    assert_end_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        token_done_o |-> (!busy_o && pc_o == '0 && unit_start_o == '0));

    // R8: nothing is started while frozen
    assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> (unit_start_o == '0));

    // R9: a done pulse while idle is flagged and starts nothing
    assert_idle_done_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && |unit_done_i) |=> (proto_err_o && unit_start_o == '0));

endmodule

// File: tb/useq_dispatch_test.sv
`timescale 1ns/1ps
module useq_dispatch_test;

    localparam int N     = 8;
    localparam int DEPTH = 32;
    localparam int PW    = 5;
    localparam int WW    = 36;
    localparam int REAL_OPS = 17;

    // Program: ops 0..19, skipped selects at 3, 10, 17, end marker at 20.
    function automatic logic [WW-1:0] prog_word(input int i);
        int unsigned h;
        logic [3:0]  sel;
        h = 32'(i) * 32'h9E3779B1 + 32'h7F4A7C15;
        h = h ^ (h >> 13);
        h = h * 32'h85EBCA6B;
        h = h ^ (h >> 16);
        if (i == 20)      sel = 4'hF;
        else if (i == 3)  sel = 4'd9;
        else if (i == 10) sel = 4'd12;
        else if (i == 17) sel = 4'd14;
        else if (i > 20)  sel = 4'd0;
        else              sel = 4'((i * 5) % 8);
        return {sel, h};
    endfunction

    function automatic logic [DEPTH*WW-1:0] build_image();
        logic [DEPTH*WW-1:0] img;
        img = '0;
        for (int i = 0; i < DEPTH; i++) img[i*WW +: WW] = prog_word(i);
        return img;
    endfunction

    localparam logic [DEPTH*WW-1:0] IMG = build_image();

    function automatic int next_stop(input int from);
        for (int j = from; j < DEPTH; j++) begin
            logic [3:0] s;
            s = prog_word(j)[35:32];
            if (s < 4'd8 || s == 4'hF) return j;
        end
        return DEPTH - 1;
    endfunction

    logic          clk = 1'b0;
    logic          rst_n;
    logic          run_i, halt_i;
    logic [N-1:0]  stub_done, stray_done, done_bus;
    logic [N-1:0]  unit_start_o;
    logic [3:0]    op_mode_o;
    logic [9:0]    op_base_a_o, op_base_b_o;
    logic [7:0]    op_count_o;
    logic [PW-1:0] pc_o;
    logic          busy_o, halted_o, token_done_o, proto_err_o;

    assign done_bus = stub_done | stray_done;

    always #2 clk = ~clk;

    useq_dispatch #(
        .NUM_UNITS (N),
        .DEPTH     (DEPTH),
        .ROM_IMAGE (IMG)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_i),
        .halt_i       (halt_i),
        .unit_done_i  (done_bus),
        .unit_start_o (unit_start_o),
        .op_mode_o    (op_mode_o),
        .op_base_a_o  (op_base_a_o),
        .op_base_b_o  (op_base_b_o),
        .op_count_o   (op_count_o),
        .pc_o         (pc_o),
        .busy_o       (busy_o),
        .halted_o     (halted_o),
        .token_done_o (token_done_o),
        .proto_err_o  (proto_err_o)
    );

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int tokens = 0;
    int out_unit = -1;
    bit halt_mode = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Unit stubs: random latency 0..4 cycles after the start becomes visible.
    initial begin
        bit pend;
        int pu, cnt;
        void'($urandom(32'd2024));
        pend = 0; pu = 0; cnt = 0;
        stub_done = '0;
        forever begin
            @(posedge clk); #1;
            stub_done = '0;
            if (|unit_start_o) begin
                for (int k = 0; k < N; k++) if (unit_start_o[k]) pu = k;
                pend = 1;
                cnt  = int'($urandom % 5);
            end
            if (pend) begin
                if (cnt == 0) begin
                    stub_done[pu] = 1'b1;
                    pend = 0;
                end else cnt--;
            end
        end
    end

    // Monitor: order, fields, timing and end of token.
    initial begin
        int cyc, exp_pc, due, s, idx;
        bit due_end;
        logic [WW-1:0] cur;
        cyc = 0; exp_pc = 0; due = -1; due_end = 0; cur = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (due == cyc) begin
                    if (due_end) begin
                        check(token_done_o == 1'b1, "R7 end pulse timing", 64'(token_done_o), 64'd1);
                        check(!busy_o && pc_o == '0 && unit_start_o == '0, "R7 idle and rewound",
                              {busy_o, 3'b0, 8'(pc_o), unit_start_o}, 64'd0);
                    end else begin
                        check(|unit_start_o, "R5 R6 next start two cycles after done plus skips",
                              64'(unit_start_o), 64'd1);
                    end
                    due = -1;
                end
                if (|unit_start_o) begin
                    starts++;
                    check(out_unit < 0, "R5 start while a unit is outstanding", 64'(out_unit), 64'hFFFF);
                    check($countones(unit_start_o) == 1, "R3 single start bit", 64'(unit_start_o), 64'd1);
                    s   = next_stop(exp_pc);
                    cur = prog_word(s);
                    idx = 0;
                    for (int k = 0; k < N; k++) if (unit_start_o[k]) idx = k;
                    check(idx == int'(cur[35:32]), "R3 started unit follows program", 64'(idx), 64'(cur[35:32]));
                    check({op_mode_o, op_base_a_o, op_base_b_o, op_count_o} == cur[31:0],
                          "R4 operand fields", {op_mode_o, op_base_a_o, op_base_b_o, op_count_o}, cur[31:0]);
                    out_unit = idx;
                    exp_pc   = s + 1;
                end else if (out_unit >= 0) begin
                    check({op_mode_o, op_base_a_o, op_base_b_o, op_count_o} == cur[31:0],
                          "R4 operands held while waiting", {op_mode_o, op_base_a_o, op_base_b_o, op_count_o}, cur[31:0]);
                end
                if (out_unit >= 0 && done_bus[out_unit]) begin
                    out_unit = -1;
                    if (!halt_mode) begin
                        s       = next_stop(exp_pc);
                        due     = cyc + 2 + (s - exp_pc);
                        due_end = (prog_word(s)[35:32] == 4'hF);
                    end
                end
                if (token_done_o) begin
                    tokens++;
                    exp_pc = 0;
                end
            end
        end
    end

    task automatic pulse_run();
        @(posedge clk); #1 run_i = 1'b1;
        @(posedge clk); #1 run_i = 1'b0;
    endtask

    task automatic apply_reset();
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_token(input int t0, input string tag);
        for (int k = 0; k < 3000 && tokens == t0; k++) @(posedge clk);
        check(tokens == t0 + 1, tag, 64'(tokens), 64'(t0 + 1));
    endtask

    initial begin
        int s0, t0, snap;
        run_i = 0; halt_i = 0; stray_done = '0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(pc_o == '0, "R1 pc after reset", 64'(pc_o), 64'd0);
        check(unit_start_o == '0, "R1 no start after reset", 64'(unit_start_o), 64'd0);
        check(!busy_o && !halted_o, "R1 busy and halted low", {busy_o, halted_o}, 64'd0);
        check(!token_done_o && !proto_err_o, "R1 end and error low", {token_done_o, proto_err_o}, 64'd0);

        // R9: done while idle
        @(posedge clk); #1 stray_done = 8'h04;
        @(posedge clk); #1 stray_done = '0;
        @(negedge clk);
        check(proto_err_o == 1'b1, "R9 idle done flagged", 64'(proto_err_o), 64'd1);
        check(pc_o == '0 && !busy_o && unit_start_o == '0, "R9 idle done has no effect",
              {busy_o, 8'(pc_o), unit_start_o}, 64'd0);
        apply_reset();
        check(proto_err_o == 1'b0, "R1 reset clears error", 64'(proto_err_o), 64'd0);

        // R2: first token with a redundant run pulse mid-way
        s0 = starts; t0 = tokens;
        pulse_run();
        repeat (12) @(posedge clk);
        #1 run_i = 1'b1;
        @(posedge clk); #1 run_i = 1'b0;
        @(negedge clk);
        check(busy_o == 1'b1, "R2 still busy after extra run", 64'(busy_o), 64'd1);
        wait_token(t0, "R7 first token ends");
        @(posedge clk);
        check(starts - s0 == REAL_OPS, "R2 dispatch count unaffected by extra run", 64'(starts - s0), 64'(REAL_OPS));

        // R9: stray done from a unit not awaited
        s0 = starts; t0 = tokens;
        pulse_run();
        for (int k = 0; k < 200 && out_unit < 0; k++) @(posedge clk);
        #1 stray_done = N'(1 << ((out_unit + 1) % N));
        @(posedge clk); #1 stray_done = '0;
        @(negedge clk);
        check(proto_err_o == 1'b1, "R9 stray done flagged", 64'(proto_err_o), 64'd1);
        wait_token(t0, "R9 token completes after stray done");
        @(posedge clk);
        check(starts - s0 == REAL_OPS, "R9 schedule unaffected", 64'(starts - s0), 64'(REAL_OPS));
        check(proto_err_o == 1'b1, "R9 error stays set", 64'(proto_err_o), 64'd1);

        // R8: halt in the middle of a token, then resume
        s0 = starts; t0 = tokens;
        halt_mode = 1'b1;
        pulse_run();
        for (int k = 0; k < 400 && starts < s0 + 4; k++) @(posedge clk);
        #1 halt_i = 1'b1;
        @(posedge clk); #1 halt_i = 1'b0;
        repeat (8) @(posedge clk);
        snap = starts;
        repeat (6) @(posedge clk);
        check(starts == snap && starts == s0 + 4, "R8 no dispatch while halted", 64'(starts), 64'(s0 + 4));
        @(negedge clk);
        check(halted_o && busy_o, "R8 halted and busy", {halted_o, busy_o}, 64'h3);
        halt_mode = 1'b0;
        pulse_run();
        @(negedge clk);
        check(!halted_o, "R8 resume leaves halt", 64'(halted_o), 64'd0);
        wait_token(t0, "R8 halted token completes");
        @(posedge clk);
        check(starts - s0 == REAL_OPS, "R8 full schedule after resume", 64'(starts - s0), 64'(REAL_OPS));

        // R7 R3 R5: more tokens under random unit latency
        for (int t = 0; t < 6; t++) begin
            s0 = starts; t0 = tokens;
            repeat (int'($urandom % 4)) @(posedge clk);
            pulse_run();
            wait_token(t0, "R7 repeated token ends");
            @(posedge clk);
            check(starts - s0 == REAL_OPS, "R3 dispatches per token", 64'(starts - s0), 64'(REAL_OPS));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule